// File: doc/BRIEF.md
# Striped Readout Word Formatter

This block sits between the hit-finding core of a strip readout chip and its serial output pins. Hit records arrive in the crossing clock domain. Each one carries a strip index, a logic-group index and the crossing number of the hit. The block moves each record into the readout clock domain through a two-entry gray-pointer synchroniser. There it becomes a 24-bit data word. When no record is waiting at a word boundary, the block emits a 24-bit sync/status word instead, so the output stream never goes idle.

Every word is spread over 1, 2, 4 or 6 serial lanes, chosen at run time. Each lane carries two bits per readout clock cycle, so a word lasts 12, 6, 3 or 2 cycles. The block holds no output buffer. It keeps only the two synchroniser slots, and the core sees backpressure as soon as both slots are full.

Top module: `strip_word_serializer`

## Requirements
- R1: A data word is {1'b1, strip[3:0], group[4:0], crossing[7:0], 6'b000000}, most significant bit first, so bit 23 (the word mark) is 1.
- R2: A sync/status word is {1'b0, status[9:0], 13'h1ABC}. The status value is the one present on `status` at the readout clock edge that starts the word.
- R3: `lane_sel` encodes 0 = 1 lane, 1 = 2 lanes, 2 = 4 lanes, 3 = 6 lanes. A word with L lanes lasts 12/L readout cycles. In cycle c of a word, lane l drives word bit 23-(2Lc+l) on `lane_bits[2l+1]` and word bit 23-(2Lc+L+l) on `lane_bits[2l]`.
- R4: Lanes at or above the active lane count drive 0 on both of their bits in every cycle.
- R5: A change on `lane_sel` takes effect only at the next word start. The word already in progress finishes with the lane count it started with.
- R6: Every accepted hit record appears exactly once, in acceptance order, as a data word. No sync word starts later than 25 ns after a still-undelivered record was accepted.
- R7: `hit_ready` falls while two records are waiting. A record offered while `hit_ready` is low is not taken, and it is taken once at a later edge.
- R8: While `rrst_n` is low all lane bits are 0. While `xrst_n` is low `hit_ready` is 1. The first word starts at the first readout clock edge after `rrst_n` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xclk | input | 1 | Crossing-domain clock |
| xrst_n | input | 1 | Synchronous active-low reset, crossing domain |
| hit_valid | input | 1 | Hit record offered |
| hit_strip | input | 4 | Strip index within its group |
| hit_group | input | 5 | Logic-group index |
| hit_bco | input | 8 | Crossing number of the hit |
| hit_ready | output | 1 | Record accepted at this edge when high together with hit_valid |
| rclk | input | 1 | Readout clock |
| rrst_n | input | 1 | Synchronous active-low reset, readout domain |
| lane_sel | input | 2 | Active lane count code |
| status | input | 10 | Status bits placed in sync words |
| lane_bits | output | 12 | Two bits per lane; lane l at [2l+1:2l], [2l+1] sent first |

## Verification
Lane bits are valid one readout edge after a word starts. Every later cycle of the word follows one edge after the one before. The bench counts readout edges from reset release, just as the block does. It samples `lane_bits` on the falling edge of the readout clock, and it captures `lane_sel` and `status` at the rising edge that starts each word. The latency of a hit record through the synchroniser depends on the phase between the two clocks. For that reason each finished data word is compared with the oldest outstanding record rather than at a fixed cycle. The "no idle while pending" rule is checked against a 25 ns bound, which covers two synchroniser stages plus one pop edge.

// File: rtl/ssr_pkg.sv
// Shared widths, the hit record type and lane-mode decoding for the
// striped readout word formatter. Assumes a 24-bit word and a 2-bit lane code.
package ssr_pkg;
    localparam int STRIP_W   = 4;
    localparam int GROUP_W   = 5;
    localparam int BCO_W     = 8;
    localparam int STAT_W    = 10;
    localparam int SYNC_W    = 13;
    localparam int WORD_W    = 24;
    localparam int MAX_LANES = 6;
    localparam int PAD_W     = WORD_W - 1 - STRIP_W - GROUP_W - BCO_W;
    localparam logic [SYNC_W-1:0] SYNC_PAT = 13'h1ABC;

    typedef struct packed {
        logic [STRIP_W-1:0] strip;
        logic [GROUP_W-1:0] group;
        logic [BCO_W-1:0]   bco;
    } hit_t;

    localparam int HIT_W = $bits(hit_t);

    // Number of active lanes for a lane code.
    function automatic int lanes_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 6;
        endcase
    endfunction

    // Readout cycles needed for one word at a lane code (two bits per lane per cycle).
    function automatic int cycles_of(input logic [1:0] sel);
        return WORD_W / (2 * lanes_of(sel));
    endfunction
endpackage

// File: rtl/hit_cdc_fifo.sv
// Two-entry asynchronous FIFO carrying hit records from the crossing clock
// to the readout clock. Pointers are 2-bit gray codes, and each one passes
// through a two-flop synchroniser. Assumes the data slots are read only
// after the synchronised write pointer shows them filled.
module hit_cdc_fifo #(
    parameter int W = 17
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         w_valid,
    input  logic [W-1:0] w_data,
    output logic         w_ready,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         r_pop,
    output logic [W-1:0] r_data,
    output logic         r_empty
);
    localparam int PW = 2;

    logic [W-1:0]  mem [2];
    logic [PW-1:0] wbin, wgray, rq1, rq2;
    logic [PW-1:0] rbin, rgray, wq1, wq2;
    logic [PW-1:0] wbin_nx, rbin_nx;

    assign wbin_nx = wbin + 2'd1;
    assign rbin_nx = rbin + 2'd1;
    assign w_ready = (wgray != ~rq2);
    assign r_empty = (rgray == wq2);
    assign r_data  = mem[rbin[0]];

    // Write side: store a record and advance the write pointer on handshake.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (w_valid && w_ready) begin
            mem[wbin[0]] <= w_data;
            wbin         <= wbin_nx;
            wgray        <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Bring the read pointer into the write domain.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            rq1 <= '0;
            rq2 <= '0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
        end
    end

    // Read side: advance the read pointer on pop.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (r_pop && !r_empty) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Bring the write pointer into the read domain.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            wq1 <= '0;
            wq2 <= '0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
        end
    end

    // R6
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        $onehot0(wgray ^ $past(wgray)));

    // R6
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/word_striper.sv
// Loads a 24-bit word when the previous one is finished and deals it
// round-robin over the active lanes, two bits per lane per cycle, most
// significant bit first. The lane code is captured only at word load.
// Assumes WORD_W is divisible by 2*L for every supported lane count L.
module word_striper
    import ssr_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int NL = MAX_LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] word_in,
    input  logic [1:0]    lane_sel,
    output logic          load,
    output logic [2*NL-1:0] lane_bits
);
    localparam int CNT_W = $clog2(WW / 2);

    logic [WW-1:0]    sh;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       act;
    int               nl;

    assign load = (cnt == '0);
    assign nl   = lanes_of(act);

    // Word shifter: load on the last cycle of a word, otherwise advance by 2*nl bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
            act <= 2'd0;
        end else if (load) begin
            sh  <= word_in;
            act <= lane_sel;
            cnt <= CNT_W'(cycles_of(lane_sel) - 1);
        end else begin
            sh  <= sh << (2 * nl);
            cnt <= cnt - 1'b1;
        end
    end

    // Lane fan-out: first bit of each lane from the top nl bits, second from the next nl.
    always_comb begin
        lane_bits = '0;
        for (int l = 0; l < NL; l++) begin
            if (l < nl) begin
                lane_bits[2*l+1] = sh[WW-1-l];
                lane_bits[2*l]   = sh[WW-1-nl-l];
            end
        end
    end

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < cycles_of(act));

    // R4
    idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd0) |-> (lane_bits[2*NL-1:2] == '0));
endmodule

// File: rtl/strip_word_serializer.sv
// Top of the striped readout word formatter. Hit records cross from the
// crossing domain through a two-entry FIFO. At each word boundary the oldest
// waiting record becomes a data word; with none waiting a sync/status word
// is sent. Assumes status and lane_sel are synchronous to rclk.
module strip_word_serializer
    import ssr_pkg::*;
(
    input  logic                 xclk,
    input  logic                 xrst_n,
    input  logic                 hit_valid,
    input  logic [STRIP_W-1:0]   hit_strip,
    input  logic [GROUP_W-1:0]   hit_group,
    input  logic [BCO_W-1:0]     hit_bco,
    output logic                 hit_ready,
    input  logic                 rclk,
    input  logic                 rrst_n,
    input  logic [1:0]           lane_sel,
    input  logic [STAT_W-1:0]    status,
    output logic [2*MAX_LANES-1:0] lane_bits
);
    hit_t              w_rec, r_rec;
    logic [HIT_W-1:0]  r_raw;
    logic              r_empty, have_hit, load, pop;
    logic [WORD_W-1:0] next_word;

    assign w_rec    = '{strip: hit_strip, group: hit_group, bco: hit_bco};
    assign r_rec    = hit_t'(r_raw);
    assign have_hit = !r_empty;
    assign pop      = load && have_hit;

    // Word selection: data word when a record waits, otherwise sync/status.
    always_comb begin
        if (have_hit)
            next_word = {1'b1, r_rec.strip, r_rec.group, r_rec.bco, {PAD_W{1'b0}}};
        else
            next_word = {1'b0, status, SYNC_PAT};
    end

    hit_cdc_fifo #(.W(HIT_W)) u_fifo (
        .wclk    (xclk),
        .wrst_n  (xrst_n),
        .w_valid (hit_valid),
        .w_data  (w_rec),
        .w_ready (hit_ready),
        .rclk    (rclk),
        .rrst_n  (rrst_n),
        .r_pop   (pop),
        .r_data  (r_raw),
        .r_empty (r_empty)
    );

    word_striper #(.WW(WORD_W), .NL(MAX_LANES)) u_striper (
        .clk       (rclk),
        .rst_n     (rrst_n),
        .word_in   (next_word),
        .lane_sel  (lane_sel),
        .load      (load),
        .lane_bits (lane_bits)
    );

    // R1
    mark_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        load |=> (lane_bits[1] == $past(have_hit)));
endmodule

// File: tb/strip_word_serializer_tb.sv
`timescale 1ns/1ps
module strip_word_serializer_tb;
    logic        xclk = 1'b0, rclk = 1'b0;
    logic        xrst_n, rrst_n, hit_valid, hit_ready;
    logic [3:0]  hit_strip;
    logic [4:0]  hit_group;
    logic [7:0]  hit_bco;
    logic [1:0]  lane_sel;
    logic [9:0]  status;
    logic [11:0] lane_bits;

    int total = 0, bad = 0, words_data = 0, hits_sent = 0;
    bit done = 0, saw_full = 0;

    logic [23:0] q_word[$];
    realtime     q_t[$];

    // model state
    bit          m_act = 0;
    int          m_cnt = 0, m_pos = 0, m_L = 1, m_cyc = 12;
    logic [9:0]  m_stat;
    logic [23:0] m_word;
    realtime     m_load_t;

    always #2.5 rclk = ~rclk;
    always #3.5 xclk = ~xclk;

    strip_word_serializer u_dut (
        .xclk(xclk), .xrst_n(xrst_n), .hit_valid(hit_valid),
        .hit_strip(hit_strip), .hit_group(hit_group), .hit_bco(hit_bco),
        .hit_ready(hit_ready), .rclk(rclk), .rrst_n(rrst_n),
        .lane_sel(lane_sel), .status(status), .lane_bits(lane_bits)
    );

    function automatic int lanes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 6;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference word timing: a word starts whenever the previous one is used up (R3, R5, R8).
    always @(posedge rclk) begin
        if (!rrst_n) begin
            m_act = 0;
            m_cnt = 0;
        end else begin
            m_act = 1;
            if (m_cnt == 0) begin
                m_L      = lanes(lane_sel);
                m_cyc    = 12 / m_L;
                m_pos    = 0;
                m_cnt    = m_cyc - 1;
                m_stat   = status;
                m_load_t = $realtime;
                m_word   = '0;
            end else begin
                m_pos++;
                m_cnt--;
            end
        end
    end

    // Compare lane outputs on every falling readout edge.
    always @(negedge rclk) begin
        if (!m_act) begin
            check(lane_bits == 12'h000, "R8 reset lanes", lane_bits, 0);
        end else begin
            for (int l = 0; l < 6; l++) begin
                if (l < m_L) begin
                    m_word[23 - (2*m_L*m_pos + l)]       = lane_bits[2*l+1];
                    m_word[23 - (2*m_L*m_pos + m_L + l)] = lane_bits[2*l];
                end else begin
                    check(lane_bits[2*l+1 -: 2] == 2'b00, "R4 inactive lane", lane_bits, 0);
                end
            end
            if (m_pos == m_cyc - 1) begin
                if (m_word[23]) begin
                    words_data++;
                    if (q_word.size() == 0) begin
                        check(0, "R6 data word with no hit", m_word, 0);
                    end else begin
                        check(m_word == q_word[0], "R1 R3 R5 R6 data word", m_word, q_word[0]);
                        void'(q_word.pop_front());
                        void'(q_t.pop_front());
                    end
                end else begin
                    check(m_word == {1'b0, m_stat, 13'h1ABC}, "R2 R3 R5 sync word",
                          m_word, {1'b0, m_stat, 13'h1ABC});
                    if (q_t.size() != 0)
                        check(q_t[0] + 25.0 >= m_load_t, "R6 sync sent while hit pending",
                              32'($rtoi(m_load_t)), 32'($rtoi(q_t[0])));
                end
            end
        end
    end

    // Offer one hit and hold it until the handshake completes (R7).
    task automatic send_hit(input logic [3:0] s, input logic [4:0] g, input logic [7:0] b);
        @(negedge xclk);
        hit_valid = 1'b1;
        hit_strip = s;
        hit_group = g;
        hit_bco   = b;
        while (!hit_ready) begin
            saw_full = 1;
            @(negedge xclk);
        end
        @(posedge xclk);
        q_word.push_back({1'b1, s, g, b, 6'b000000});
        q_t.push_back($realtime);
        hits_sent++;
        @(negedge xclk);
        hit_valid = 1'b0;
    endtask

    task automatic wait_r(input int n);
        repeat (n) @(negedge rclk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        xrst_n = 0; rrst_n = 0; hit_valid = 0;
        hit_strip = 0; hit_group = 0; hit_bco = 0;
        lane_sel = 2'd0; status = 10'h2A5;
        wait_r(6);
        check(hit_ready == 1'b1, "R8 reset hit_ready", hit_ready, 1);
        xrst_n = 1; rrst_n = 1;

        // R2: idle single-lane sync words, then a status change
        wait_r(40);
        status = 10'h0F3;
        wait_r(30);

        // R1: single hit, single lane
        send_hit(4'hA, 5'h13, 8'hC5);
        wait_r(30);

        // R3: each lane count with boundary field values
        lane_sel = 2'd1;
        send_hit(4'h0, 5'h00, 8'h00);
        send_hit(4'hF, 5'h1F, 8'hFF);
        wait_r(30);
        lane_sel = 2'd2;
        status = 10'h3FF;
        send_hit(4'h5, 5'h0A, 8'h5A);
        wait_r(20);
        lane_sel = 2'd3;
        status = 10'h000;
        send_hit(4'h3, 5'h15, 8'hA3);
        send_hit(4'hC, 5'h06, 8'h3C);
        wait_r(20);

        // R5: lane code toggled in the middle of words
        for (int i = 0; i < 16; i++) begin
            lane_sel = 2'(i * 3 + 1);
            status   = 10'(i * 37 + 5);
            if (i % 4 == 0) send_hit(4'(i), 5'(i + 7), 8'(i * 11));
            wait_r(3 + (i % 5));
        end
        wait_r(30);

        // R7: back-to-back hits on one lane fill the two slots
        lane_sel = 2'd0;
        wait_r(15);
        for (int i = 0; i < 5; i++) send_hit(4'(i + 9), 5'(i * 5), 8'(8'hE0 + i));
        check(saw_full == 1, "R7 hit_ready dropped when full", saw_full, 1);

        // R6: drain, then everything must have arrived
        wait_r(200);
        check(q_word.size() == 0, "R6 hits left undelivered", q_word.size(), 0);
        check(words_data == hits_sent, "R6 data word count", words_data, hits_sent);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule